// File: doc/BRIEF.md
# Hot-plug slot reset and indicator sequencer

This block drives the active-low slot reset and power-indicator outputs of a PCI Express downstream port when no slot power controller is used. It waits for the upstream fundamental reset to end and for the configuration load to finish. It then releases the slot reset and lights the power indicator. After that, software can assert or release the slot reset through the power controller control bit. The power-enable and clock-enable outputs are driven inactive for the whole time.

The controller has four states. WAIT_RESET is entered while the synchronized upstream reset is active. It moves to WAIT_CONFIG on the first clock after that reset ends. WAIT_CONFIG waits for the configuration-done strobe. On that strobe it moves to WAIT_LATCH if the EEPROM was blank, and to RUN otherwise. WAIT_LATCH moves to RUN once the synchronized retention latch sense reads low (latch closed). This transition also marks the slot as released. RUN is held until the next upstream reset. In RUN the control bit is honoured when the power controller is absent or once the slot has been released. When it is honoured, the control bit drives the slot reset directly.

Both asynchronous inputs pass through two-flop synchronizers: the upstream reset (asserted asynchronously, released synchronously) and the latch sense. Both outputs come straight from flops.

Top module: `hp_slot_rst_led_seq`

## Requirements
- R1: While the upstream reset is low, and for two clocks after it rises, slot_rst_n is 0 and pwr_led_n is 1. Assertion of the upstream reset forces these values at once, without waiting for a clock.
- R2: A strobe is accepted when cfg_done is 1 in WAIT_CONFIG with eeprom_blank 0. If cap_pwrctl_present is 0 and ctl_slot_reset is 0 at that strobe, slot_rst_n goes to 1 on the second rising edge, counting the edge that sampled the strobe. On the same edge pwr_led_n goes to 0 when cap_ind_present is 1.
- R3: When cap_ind_present is 0, pwr_led_n is 1 on the edge after, whatever the other inputs are.
- R4: When eeprom_blank is 1 at the accepted strobe, the outputs stay at slot_rst_n 0 and pwr_led_n 1 while latch_sense_n is high. Once latch_sense_n goes low before edge j, the outputs release on edge j+3.
- R5: In RUN with control honoured, ctl_slot_reset 1 drives slot_rst_n to 0 and ctl_slot_reset 0 drives it to 1. The pin follows on the first rising edge that samples the new bit value.
- R6: Control is honoured only when cap_pwrctl_present is 0 or the slot has already been released since the last upstream reset. Otherwise slot_rst_n stays 0 and pwr_led_n stays 1.
- R7: pwr_en_n and clk_en_n are always 1.
- R8: Once the slot has been released, latch_sense_n has no further effect on either output.
- R9: cfg_done is ignored outside WAIT_CONFIG. This includes the WAIT_RESET clock, the first clock after the synchronized reset ends, and all of RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| up_rst_n | input | 1 | Upstream fundamental reset, active low, asynchronous |
| cfg_done | input | 1 | One-cycle strobe at the end of configuration load |
| cap_pwrctl_present | input | 1 | Capability bit: slot power controller present |
| cap_ind_present | input | 1 | Capability bit: power indicator present |
| ctl_slot_reset | input | 1 | Control bit: 1 asserts the slot reset, 0 releases it |
| eeprom_blank | input | 1 | Configuration came from defaults because the EEPROM was blank |
| latch_sense_n | input | 1 | Retention latch sense, low when closed, asynchronous |
| slot_rst_n | output | 1 | Slot reset, active low, registered |
| pwr_led_n | output | 1 | Power indicator, active low, registered |
| pwr_en_n | output | 1 | Slot power enable, held inactive high |
| clk_en_n | output | 1 | Slot reference clock enable, held inactive high |

## Verification
The bench model predicts each result on its own latency. A control-bit change shows on the pin at the edge that samples it. A configuration strobe releases the outputs one edge after the edge that samples it. A latch closure takes two synchronizer edges plus one state edge plus one output edge. Reset exit takes three edges before a strobe can be accepted. Every value is compared 1 ns after each rising edge, so registered changes are seen once they have settled. Directed checks at those exact edges also confirm the value one edge early, which catches any added or missing register stage.

// File: rtl/hp_seq_pkg.sv
package hp_seq_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_RESET  = 2'd0,
        ST_WAIT_CONFIG = 2'd1,
        ST_WAIT_LATCH  = 2'd2,
        ST_RUN         = 2'd3
    } hp_state_e;

    // Idle levels of the active-low slot outputs
    localparam logic SLOT_HELD   = 1'b0;
    localparam logic LED_DARK    = 1'b1;
    localparam logic ENABLE_IDLE = 1'b1;

endpackage

// File: rtl/hp_reset_sync.sv
// Asynchronous assertion, synchronous release; STAGES must be 2 or more.
module hp_reset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[TOP-1:0], 1'b1};
        end
    end

    assign srst_n = chain[TOP];
endmodule

// File: rtl/hp_bit_sync.sv
// Multi-flop synchronizer for a level input; STAGES must be 2 or more.
module hp_bit_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[TOP-1:0], din};
        end
    end

    assign dout = chain[TOP];
endmodule

// File: rtl/hp_seq_fsm.sv
module hp_seq_fsm
    import hp_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_done,
    input  logic      eeprom_blank,
    input  logic      latch_closed,
    input  logic      pwrctl_present,
    input  logic      ctl_slot_reset,
    output hp_state_e state,
    output logic      released,
    output logic      release_now
);
    hp_state_e state_nx;
    logic      ctl_honoured;
    logic      latch_release;

    // Software control is honoured without a power controller, or after release
    assign ctl_honoured  = !pwrctl_present || released;
    assign release_now   = (state == ST_RUN) && ctl_honoured && !ctl_slot_reset;
    assign latch_release = (state == ST_WAIT_LATCH) && latch_closed;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT_RESET:  state_nx = ST_WAIT_CONFIG;
            ST_WAIT_CONFIG: begin
                if (cfg_done) begin
                    state_nx = eeprom_blank ? ST_WAIT_LATCH : ST_RUN;
                end
            end
            ST_WAIT_LATCH:  begin
                if (latch_closed) begin
                    state_nx = ST_RUN;
                end
            end
            ST_RUN:         state_nx = ST_RUN;
            default:        state_nx = ST_WAIT_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT_RESET;
        end else begin
            state <= state_nx;
        end
    end

    // Sticky mark: the slot has left reset at least once since upstream reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            released <= 1'b0;
        end else if (release_now || latch_release) begin
            released <= 1'b1;
        end
    end
endmodule

// File: rtl/hp_out_regs.sv
module hp_out_regs
    import hp_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  hp_state_e state,
    input  logic      released,
    input  logic      release_now,
    input  logic      ind_present,
    output logic      slot_rst_n,
    output logic      pwr_led_n
);
    logic led_on;

    assign led_on = (state == ST_RUN) && ind_present && (released || release_now);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_rst_n <= SLOT_HELD;
            pwr_led_n  <= LED_DARK;
        end else begin
            slot_rst_n <= release_now ? ~SLOT_HELD : SLOT_HELD;
            pwr_led_n  <= led_on ? ~LED_DARK : LED_DARK;
        end
    end
endmodule

// File: rtl/hp_slot_rst_led_seq.sv
module hp_slot_rst_led_seq
    import hp_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic up_rst_n,
    input  logic cfg_done,
    input  logic cap_pwrctl_present,
    input  logic cap_ind_present,
    input  logic ctl_slot_reset,
    input  logic eeprom_blank,
    input  logic latch_sense_n,
    output logic slot_rst_n,
    output logic pwr_led_n,
    output logic pwr_en_n,
    output logic clk_en_n
);
    logic      rst_sync_n;
    logic      latch_sync_n;
    logic      latch_closed;
    hp_state_e state;
    logic      released;
    logic      release_now;

    hp_reset_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk    (clk),
        .arst_n (up_rst_n),
        .srst_n (rst_sync_n)
    );

    hp_bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_latch_sync (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .din   (latch_sense_n),
        .dout  (latch_sync_n)
    );

    assign latch_closed = ~latch_sync_n;

    hp_seq_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_sync_n),
        .cfg_done       (cfg_done),
        .eeprom_blank   (eeprom_blank),
        .latch_closed   (latch_closed),
        .pwrctl_present (cap_pwrctl_present),
        .ctl_slot_reset (ctl_slot_reset),
        .state          (state),
        .released       (released),
        .release_now    (release_now)
    );

    hp_out_regs u_out (
        .clk         (clk),
        .rst_n       (rst_sync_n),
        .state       (state),
        .released    (released),
        .release_now (release_now),
        .ind_present (cap_ind_present),
        .slot_rst_n  (slot_rst_n),
        .pwr_led_n   (pwr_led_n)
    );

    // This path never runs the power controller handshake
    assign pwr_en_n = ENABLE_IDLE;
    assign clk_en_n = ENABLE_IDLE;
endmodule

// File: rtl/hp_seq_checker.sv
module hp_seq_checker
    import hp_seq_pkg::*;
(
    input logic      clk,
    input logic      rst_sync_n,
    input logic      cfg_done,
    input logic      cap_pwrctl_present,
    input logic      cap_ind_present,
    input logic      ctl_slot_reset,
    input hp_state_e state,
    input logic      released,
    input logic      slot_rst_n,
    input logic      pwr_led_n
);
    // R1: outputs held while the synchronized reset is active
    always @(negedge clk) begin
        if (rst_sync_n === 1'b0) begin
            p_reset_hold_r1: assert (slot_rst_n === 1'b0 && pwr_led_n === 1'b1)
                else $error("slot outputs not held during reset");
        end
    end

    p_led_after_release_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !pwr_led_n |-> released)
        else $error("indicator lit before slot release");

    p_led_dark_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !cap_ind_present |=> pwr_led_n)
        else $error("indicator lit without indicator present");

    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (state == ST_WAIT_LATCH) |-> (!slot_rst_n && pwr_led_n))
        else $error("outputs moved while waiting for latch");

    p_ctl_assert_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (state == ST_RUN && released && ctl_slot_reset) |=> !slot_rst_n)
        else $error("control bit 1 did not assert slot reset");

    p_ctl_release_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (state == ST_RUN && released && !ctl_slot_reset) |=> slot_rst_n)
        else $error("control bit 0 did not release slot reset");

    p_no_honour_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (cap_pwrctl_present && !released) |=> (!slot_rst_n && pwr_led_n))
        else $error("slot released while control not honoured");

    p_strobe_gate_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (state == ST_WAIT_CONFIG && !cfg_done) |=> (state == ST_WAIT_CONFIG))
        else $error("left configuration wait without strobe");
endmodule

bind hp_slot_rst_led_seq hp_seq_checker u_chk (
    .clk                (clk),
    .rst_sync_n         (rst_sync_n),
    .cfg_done           (cfg_done),
    .cap_pwrctl_present (cap_pwrctl_present),
    .cap_ind_present    (cap_ind_present),
    .ctl_slot_reset     (ctl_slot_reset),
    .state              (state),
    .released           (released),
    .slot_rst_n         (slot_rst_n),
    .pwr_led_n          (pwr_led_n)
);

// File: tb/tb_hp_slot_rst_led_seq.sv
module tb_hp_slot_rst_led_seq;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic up_rst_n = 1'b0;
    logic cfg_done = 1'b0;
    logic cap_pc = 1'b0;
    logic cap_ind = 1'b1;
    logic ctl = 1'b0;
    logic blank = 1'b0;
    logic latch_n = 1'b1;
    logic slot_rst_n, pwr_led_n, pwr_en_n, clk_en_n;

    hp_slot_rst_led_seq dut (
        .clk                (clk),
        .up_rst_n           (up_rst_n),
        .cfg_done           (cfg_done),
        .cap_pwrctl_present (cap_pc),
        .cap_ind_present    (cap_ind),
        .ctl_slot_reset     (ctl),
        .eeprom_blank       (blank),
        .latch_sense_n      (latch_n),
        .slot_rst_n         (slot_rst_n),
        .pwr_led_n          (pwr_led_n),
        .pwr_en_n           (pwr_en_n),
        .clk_en_n           (clk_en_n)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    started = 1'b0;
    bit    done = 1'b0;

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural model: 0 wait-reset, 1 wait-config, 2 wait-latch, 3 run
    int   edges_since = 0;
    int   m_st = 0;
    bit   m_rel = 1'b0;
    logic m_slot = 1'b0;
    logic m_led = 1'b1;
    logic lat_hist[$];
    logic seen;
    bit   honour, rel_now;
    int   nst;

    always @(posedge clk or negedge up_rst_n) begin
        if (!up_rst_n) begin
            edges_since = 0; m_st = 0; m_rel = 1'b0;
            m_slot = 1'b0; m_led = 1'b1;
            lat_hist.delete();
        end else begin
            if (edges_since < 3) edges_since++;
            if (edges_since >= 3) begin
                seen    = (lat_hist.size() >= 2) ? lat_hist[1] : 1'b1;
                honour  = !cap_pc || m_rel;
                rel_now = (m_st == 3) && honour && !ctl;
                m_slot  = rel_now;
                m_led   = !((m_st == 3) && cap_ind && (m_rel || rel_now));
                nst = m_st;
                case (m_st)
                    0: nst = 1;
                    1: if (cfg_done) nst = blank ? 2 : 3;
                    2: if (!seen) begin nst = 3; m_rel = 1'b1; end
                    default: ;
                endcase
                if (rel_now) m_rel = 1'b1;
                m_st = nst;
                lat_hist.push_front(latch_n);
                if (lat_hist.size() > 3) void'(lat_hist.pop_back());
            end
        end
    end

    always @(posedge clk) begin
        #1;
        if (started && !done) begin
            chk(cur_req, "model slot reset", slot_rst_n, m_slot);
            chk(cur_req, "model indicator", pwr_led_n, m_led);
            chk("R7", "power enable", pwr_en_n, 1'b1);
            chk("R7", "clock enable", clk_en_n, 1'b1);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_slot(logic pc, logic ind, logic c, logic b, logic l);
        @(negedge clk);
        up_rst_n = 1'b0;
        cap_pc = pc; cap_ind = ind; ctl = c; blank = b; latch_n = l; cfg_done = 1'b0;
        cyc(3);
        chk("R1", "slot reset in reset", slot_rst_n, 1'b0);
        chk("R1", "indicator in reset", pwr_led_n, 1'b1);
        up_rst_n = 1'b1;
        cyc(3);
    endtask

    // Strobe sampled at edge k; outputs due at edge k+1
    task automatic pulse_cfg(string req, logic slot_exp, logic led_exp);
        cfg_done = 1'b1;
        @(posedge clk); #1;
        chk(req, "slot one edge early", slot_rst_n, 1'b0);
        @(negedge clk);
        cfg_done = 1'b0;
        @(posedge clk); #1;
        chk(req, "slot after strobe", slot_rst_n, slot_exp);
        chk(req, "indicator after strobe", pwr_led_n, led_exp);
    endtask

    initial begin
        cyc(2);
        started = 1'b1;

        // Normal release, early strobe, runtime control
        cur_req = "R9";
        @(negedge clk);
        up_rst_n = 1'b1;
        cyc(2);
        cfg_done = 1'b1;          // sampled while still in WAIT_RESET
        @(negedge clk);
        cfg_done = 1'b0;
        cyc(3);
        chk("R9", "early strobe ignored", slot_rst_n, 1'b0);
        cur_req = "R2";
        pulse_cfg("R2", 1'b1, 1'b0);
        cur_req = "R5";
        @(negedge clk); ctl = 1'b1;
        @(posedge clk); #1;
        chk("R5", "ctl 1 asserts reset", slot_rst_n, 1'b0);
        chk("R5", "indicator stays lit", pwr_led_n, 1'b0);
        @(negedge clk); ctl = 1'b0;
        @(posedge clk); #1;
        chk("R5", "ctl 0 releases reset", slot_rst_n, 1'b1);
        cur_req = "R8";
        @(negedge clk); latch_n = 1'b0;
        cyc(4); latch_n = 1'b1;
        cyc(4);
        chk("R8", "latch ignored after release", slot_rst_n, 1'b1);
        cur_req = "R9";
        @(negedge clk); ctl = 1'b1;
        cyc(1); cfg_done = 1'b1;
        @(negedge clk); cfg_done = 1'b0;
        cyc(3);
        chk("R9", "strobe in RUN ignored", slot_rst_n, 1'b0);
        cur_req = "R6";
        @(negedge clk); ctl = 1'b0; cap_pc = 1'b1;
        @(posedge clk); #1;
        chk("R6", "released slot follows ctl with controller present", slot_rst_n, 1'b1);
        @(negedge clk); ctl = 1'b1;
        @(posedge clk); #1;
        chk("R6", "ctl 1 with controller present after release", slot_rst_n, 1'b0);
        cur_req = "R1";
        @(negedge clk); ctl = 1'b0;
        cyc(2);
        up_rst_n = 1'b0;
        #1;
        chk("R1", "async reset slot", slot_rst_n, 1'b0);
        chk("R1", "async reset indicator", pwr_led_n, 1'b1);
        cyc(2);

        // No indicator
        cur_req = "R3";
        start_slot(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        pulse_cfg("R3", 1'b1, 1'b1);
        cyc(5);
        chk("R3", "indicator dark", pwr_led_n, 1'b1);
        @(negedge clk); cap_ind = 1'b1;
        @(posedge clk); #1;
        chk("R3", "indicator lights once present", pwr_led_n, 1'b0);
        @(negedge clk); cap_ind = 1'b0;
        @(posedge clk); #1;
        chk("R3", "indicator dark again", pwr_led_n, 1'b1);

        // Blank EEPROM: latch gate
        cur_req = "R4";
        start_slot(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        pulse_cfg("R4", 1'b0, 1'b1);
        cyc(10);
        chk("R4", "held while latch open", slot_rst_n, 1'b0);
        chk("R4", "dark while latch open", pwr_led_n, 1'b1);
        latch_n = 1'b0;            // before edge j
        repeat (3) @(posedge clk);
        #1;
        chk("R4", "still held at edge j+2", slot_rst_n, 1'b0);
        @(posedge clk); #1;
        chk("R4", "released at edge j+3", slot_rst_n, 1'b1);
        chk("R4", "lit at edge j+3", pwr_led_n, 1'b0);
        cur_req = "R8";
        @(negedge clk); latch_n = 1'b1;
        cyc(6);
        chk("R8", "latch reopen ignored", slot_rst_n, 1'b1);
        chk("R8", "indicator kept", pwr_led_n, 1'b0);

        // Controller present, never released
        cur_req = "R6";
        start_slot(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        pulse_cfg("R6", 1'b0, 1'b1);
        @(negedge clk); ctl = 1'b1;
        cyc(2); ctl = 1'b0;
        cyc(3);
        chk("R6", "not honoured slot", slot_rst_n, 1'b0);
        chk("R6", "not honoured indicator", pwr_led_n, 1'b1);

        // No controller, control bit set at configuration
        cur_req = "R5";
        start_slot(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        pulse_cfg("R5", 1'b0, 1'b1);
        cyc(3);
        chk("R5", "held by ctl 1", slot_rst_n, 1'b0);
        ctl = 1'b0;
        @(posedge clk); #1;
        chk("R5", "released by ctl 0", slot_rst_n, 1'b1);
        chk("R2", "indicator lights with release", pwr_led_n, 1'b0);
        cyc(3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog R1: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule